// File: doc/BRIEF.md
# Three-Phase Windowed Mean-Square Sag Detector

This block watches one three-phase feeder. Each phase delivers a signed sample together with a one-cycle strobe at a fixed sample rate, nominally 10 kHz. For every phase the block squares the sample. It keeps the squares of the most recent `WIN_LEN` samples in a per-phase ring buffer and maintains a running sum over them: each new square is added and the square that falls out of the window is subtracted. That sum is the phase's mean-square estimate, scaled by the window length.

The smallest of the three phase sums is reported, so that a sag on any single phase shows up at once. It is compared against two programmable limits that are already given in the squared and window-scaled domain. For a reference `ref` and a fractional tolerance `tol`, the limits are `WIN_LEN·(ref·(1−tol))²` and `WIN_LEN·(ref·(1+tol))²`, so no square root is needed. One instance monitors the preferred feeder and a second monitors the alternate feeder. Transfer logic elsewhere reads the two in-band flags.

Top module: `feeder_sag_monitor`

## Requirements
- R1: While reset is high, and at the first sampling after it is released, `in_band` is 0 and `min_msq` is 0.
- R2: Let the strobe be sampled at rising edge t. From edge t+3 on, `min_msq` equals the smallest of the three phase sums. Each phase sum is the sum of the squares of that phase's most recent accepted samples, at most `WIN_LEN` of them.
- R3: A sample presented while `smp_valid` is 0 changes neither `min_msq` nor `in_band`.
- R4: `in_band` stays 0 until `WIN_LEN` strobes have been accepted since reset, even when the partial sum lies inside the limits.
- R5: Once the window is full, `in_band` is 1 exactly when `thr_lo <= min_msq <= thr_hi`. Both bounds are inclusive.
- R6: After the window has filled, each new sample displaces the oldest one, so the sum covers exactly the last `WIN_LEN` samples.
- R7: A reduced amplitude on a single phase makes that phase's sum the reported minimum and drives `in_band` to 0 when that sum falls below `thr_lo`.
- R8: A full window of the most negative sample (−32768) on all phases yields `min_msq = WIN_LEN·2^30` without overflow.
- R9: A change on `thr_lo` or `thr_hi` is reflected in `in_band` one clock later, without any new sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample set |
| smp_a | input | SW (16) | Phase A sample, signed |
| smp_b | input | SW (16) | Phase B sample, signed |
| smp_c | input | SW (16) | Phase C sample, signed |
| thr_lo | input | SUMW (40) | Lower limit on the window sum of squares |
| thr_hi | input | SUMW (40) | Upper limit on the window sum of squares |
| in_band | output | 1 | Registered flag: the window is full and the minimum lies within the limits |
| min_msq | output | SUMW (40) | Registered smallest phase sum of squares |

## Verification
Balanced samples with three distinct per-phase amplitudes are used to establish which phase supplies the minimum and to check the partial-window gating around sample `WIN_LEN`. A long run of varying samples past the fill point tells a true sliding window apart from a plain accumulator or an off-by-one window. A single-phase sag shows that the minimum switches phase and that the flag drops. Threshold steps placed exactly at and one count beyond the minimum tell inclusive bounds apart from exclusive ones. A full window of the most negative code exposes any truncation of the square or the sum, and strobe-free activity on the sample pins separates gated capture from ungated capture.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int SAMPLE_W_DEF = 16;
  localparam int WIN_LEN_DEF  = 200;
  localparam int PHASES       = 3;

  function automatic int sum_width(input int sw, input int wl);
    return 2 * sw + $clog2(wl);
  endfunction
endpackage

// File: rtl/phase_window.sv
module phase_window #(
  parameter int SW   = 16,
  parameter int WL   = 200,
  parameter int SUMW = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] in_smp,
  output logic [SUMW-1:0]      sum_o,
  output logic                 full_o
);
  localparam int SQW = 2 * SW;
  localparam int AW  = (WL > 1) ? $clog2(WL) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(WL - 1);

  logic signed [SQW-1:0] prod;
  logic [SQW-1:0] sq_q, sq_d2, old_q;
  logic [SQW-1:0] ring [WL];
  logic [AW-1:0]  ptr;
  logic           v1, v2, wrapped, sub_q, last_q;
  logic           at_last;

  assign prod    = in_smp * in_smp;
  assign at_last = (ptr == LAST_IDX);

  // stage 1: square the accepted sample
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_vld;
    if (in_vld) sq_q <= prod;
  end

  // ring buffer, read-before-write, no reset so block RAM can hold it
  always_ff @(posedge clk) begin
    if (v1) begin
      old_q     <= ring[ptr];
      ring[ptr] <= sq_q;
    end
  end

  // stage 2 control: pointer, wrap tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wrapped <= 1'b0;
      v2      <= 1'b0;
      sub_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        ptr    <= at_last ? '0 : ptr + 1'b1;
        sub_q  <= wrapped;
        last_q <= at_last;
        if (at_last) wrapped <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (v1) sq_d2 <= sq_q;
  end

  // stage 3: running sum
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      full_o <= 1'b0;
    end else if (v2) begin
      sum_o  <= sum_o + {{(SUMW-SQW){1'b0}}, sq_d2}
                      - (sub_q ? {{(SUMW-SQW){1'b0}}, old_q} : '0);
      full_o <= full_o | last_q;
    end
  end
endmodule

// File: rtl/min_of_three.sv
module min_of_three #(
  parameter int W = 40
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] m
);
  logic [W-1:0] ab;
  always_comb begin
    ab = (a < b) ? a : b;
    m  = (ab < c) ? ab : c;
  end
endmodule

// File: rtl/band_judge.sv
module band_judge #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ready,
  input  logic [W-1:0] level,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         ok_q,
  output logic [W-1:0] level_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q    <= 1'b0;
      level_q <= '0;
    end else begin
      ok_q    <= ready && (level >= lo) && (level <= hi);
      level_q <= level;
    end
  end
endmodule

// File: rtl/feeder_sag_monitor.sv
module feeder_sag_monitor
  import sag_pkg::*;
#(
  parameter int SW   = SAMPLE_W_DEF,
  parameter int WL   = WIN_LEN_DEF,
  parameter int SUMW = sum_width(SW, WL)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_a,
  input  logic signed [SW-1:0] smp_b,
  input  logic signed [SW-1:0] smp_c,
  input  logic [SUMW-1:0]      thr_lo,
  input  logic [SUMW-1:0]      thr_hi,
  output logic                 in_band,
  output logic [SUMW-1:0]      min_msq
);
  logic signed [SW-1:0] smp_arr [PHASES];
  logic [SUMW-1:0]      sums    [PHASES];
  logic [PHASES-1:0]    fulls;
  logic [SUMW-1:0]      min_w;

  assign smp_arr[0] = smp_a;
  assign smp_arr[1] = smp_b;
  assign smp_arr[2] = smp_c;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    phase_window #(.SW(SW), .WL(WL), .SUMW(SUMW)) u_win (
      .clk    (clk),
      .rst    (rst),
      .in_vld (smp_valid),
      .in_smp (smp_arr[p]),
      .sum_o  (sums[p]),
      .full_o (fulls[p])
    );
  end

  min_of_three #(.W(SUMW)) u_min (
    .a (sums[0]),
    .b (sums[1]),
    .c (sums[2]),
    .m (min_w)
  );

  band_judge #(.W(SUMW)) u_band (
    .clk     (clk),
    .rst     (rst),
    .ready   (&fulls),
    .level   (min_w),
    .lo      (thr_lo),
    .hi      (thr_hi),
    .ok_q    (in_band),
    .level_q (min_msq)
  );
endmodule

// File: rtl/sag_monitor_checker.sv
module sag_monitor_checker #(
  parameter int SW   = 16,
  parameter int WL   = 200,
  parameter int SUMW = 40
) (
  input logic            clk,
  input logic            rst,
  input logic            smp_valid,
  input logic [SUMW-1:0] thr_lo,
  input logic [SUMW-1:0] thr_hi,
  input logic            in_band,
  input logic [SUMW-1:0] min_msq
);
  localparam int CW = $clog2(WL + 1);
  localparam logic [SUMW-1:0] FS_SUM = SUMW'(WL) << (2 * SW - 2);

  logic [CW-1:0] strobes;
  logic [3:0]    vh;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobes <= '0;
      vh      <= 4'hF;
    end else begin
      vh <= {vh[2:0], smp_valid};
      if (smp_valid && strobes != CW'(WL)) strobes <= strobes + 1'b1;
    end
  end

  assert_fill_gate_R4: assert property (@(posedge clk) disable iff (rst)
    in_band |-> (strobes == CW'(WL)));

  assert_band_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    in_band |-> (($past(thr_lo) <= min_msq) && (min_msq <= $past(thr_hi))));

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (vh == 4'h0) |-> $stable(min_msq));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    min_msq <= FS_SUM);
endmodule

bind feeder_sag_monitor sag_monitor_checker #(.SW(SW), .WL(WL), .SUMW(SUMW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .thr_lo    (thr_lo),
  .thr_hi    (thr_hi),
  .in_band   (in_band),
  .min_msq   (min_msq)
);

// File: tb/feeder_sag_monitor_bench.sv
`timescale 1ns/1ps
module feeder_sag_monitor_bench;
  localparam int SW   = 16;
  localparam int WL   = 200;
  localparam int SUMW = 40;
  localparam logic [SUMW-1:0] MAXV = {SUMW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic [SUMW-1:0] thr_lo = '0, thr_hi = MAXV;
  logic            in_band;
  logic [SUMW-1:0] min_msq;

  int checks = 0;
  int failures = 0;

  longint hist [3][WL];
  int     wp = 0;
  int     cnt = 0;

  always #2.5 clk = ~clk;

  feeder_sag_monitor #(.SW(SW), .WL(WL), .SUMW(SUMW)) u_feeder_sag_monitor (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
    .thr_lo(thr_lo), .thr_hi(thr_hi),
    .in_band(in_band), .min_msq(min_msq)
  );

  function automatic longint phase_sum(input int p);
    longint s = 0;
    int n = (cnt < WL) ? cnt : WL;
    for (int k = 0; k < n; k++) s += hist[p][k];
    return s;
  endfunction

  function automatic longint exp_min();
    longint m = phase_sum(0);
    for (int p = 1; p < 3; p++) if (phase_sum(p) < m) m = phase_sum(p);
    return m;
  endfunction

  function automatic logic exp_band();
    longint m = exp_min();
    return (cnt >= WL) && (m >= longint'(thr_lo)) && (m <= longint'(thr_hi));
  endfunction

  function automatic int wave(input int amp, input int i);
    return (amp * (((i * 37) % 101) - 50)) / 50;
  endfunction

  task automatic check_val(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int a, input int b, input int c);
    @(negedge clk);
    smp_a = SW'(a); smp_b = SW'(b); smp_c = SW'(c);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    hist[0][wp] = longint'(a) * a;
    hist[1][wp] = longint'(b) * b;
    hist[2][wp] = longint'(c) * c;
    wp = (wp + 1) % WL;
    cnt++;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 in_band in reset", in_band, 0);
    check_val("R1 min_msq in reset", min_msq, 0);
    rst = 1'b0;
    @(negedge clk);
    check_val("R1 in_band after release", in_band, 0);
    check_val("R1 min_msq after release", min_msq, 0);
  endtask

  task automatic t_fill();
    thr_lo = '0; thr_hi = MAXV;
    for (int i = 0; i < WL - 1; i++) push(wave(20000, i), wave(19000, i + 7), wave(21000, i + 13));
    settle();
    check_val("R4 partial window gated", in_band, 0);
    check_val("R2 partial min", min_msq, exp_min());
    push(wave(20000, WL - 1), wave(19000, WL + 6), wave(21000, WL + 12));
    settle();
    check_val("R4 full window releases flag", in_band, 1);
    check_val("R2 full window min", min_msq, exp_min());
  endtask

  task automatic t_ignore();
    longint m0 = longint'(min_msq);
    logic   b0 = in_band;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smp_a = SW'(30000 - i); smp_b = SW'(-5 * i); smp_c = SW'(i);
    end
    settle();
    check_val("R3 min unchanged without strobe", min_msq, m0);
    check_val("R3 flag unchanged without strobe", in_band, b0);
  endtask

  task automatic t_slide();
    for (int i = 0; i < 250; i++) begin
      push(wave(15000 + 40 * i, i * 3), wave(18000, i * 5 + 1), wave(16000 - 20 * i, i + 2));
      if (i % 50 == 49) begin
        settle();
        check_val("R6 sliding window min", min_msq, exp_min());
        check_val("R5 band after slide", in_band, exp_band());
      end
    end
  endtask

  task automatic t_sag();
    for (int i = 0; i < WL; i++) push(wave(20000, i), wave(20500, i + 3), wave(21000, i + 9));
    settle();
    thr_lo = SUMW'(phase_sum(0) / 2); thr_hi = MAXV;
    @(negedge clk); @(negedge clk);
    check_val("R7 balanced in band", in_band, 1);
    for (int i = 0; i < WL; i++) push(wave(20000, i), wave(20500, i + 3), wave(6000, i + 9));
    settle();
    check_val("R7 sagged phase is min", min_msq, phase_sum(2));
    check_val("R7 sag clears flag", in_band, 0);
  endtask

  task automatic t_thresh();
    longint m = longint'(min_msq);
    @(negedge clk); thr_lo = SUMW'(m); thr_hi = MAXV;
    @(negedge clk); @(negedge clk);
    check_val("R5 R9 lower bound inclusive", in_band, 1);
    thr_lo = SUMW'(m + 1);
    @(negedge clk); @(negedge clk);
    check_val("R5 R9 just above lower bound", in_band, 0);
    thr_lo = '0; thr_hi = SUMW'(m);
    @(negedge clk); @(negedge clk);
    check_val("R5 R9 upper bound inclusive", in_band, 1);
    thr_hi = SUMW'(m - 1);
    @(negedge clk); @(negedge clk);
    check_val("R5 R9 just below upper bound", in_band, 0);
  endtask

  task automatic t_fullscale();
    thr_lo = '0; thr_hi = MAXV;
    for (int i = 0; i < WL; i++) push(-32768, -32768, -32768);
    settle();
    check_val("R8 full scale sum", min_msq, longint'(WL) * (64'd1 << 30));
    check_val("R8 full scale flag", in_band, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_ignore();
    t_slide();
    t_sag();
    t_thresh();
    t_fullscale();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule